// File: doc/BRIEF.md
# Transactional Line Buffer with Single-Cycle Commit and Abort

This block is a small, fully associative buffer that holds the tentative data of one processor core's memory transaction. The core issues three transactional access kinds: a plain transactional read, a read that announces a later write (exclusive read), and a transactional write. It also issues three control operations: a check of whether the transaction is still intact, an attempt to make the tentative writes permanent, and an unconditional discard. Every access keeps two copies of its line. One copy holds the value the line had before the transaction and is dropped if the transaction succeeds. The other holds the tentative value and is dropped if the transaction fails. Success and failure are therefore a sweep over the per-entry tags in one cycle, with no data moved.

On a miss the block asks a simplified snoopy bus for the line. The bus answers either OK with data or BUSY, and BUSY means a conflicting transaction elsewhere has refused access. A BUSY answer, or running out of replaceable entries, turns the running transaction into an orphan. An orphan keeps running until the core's next check or commit, which reports failure. Committed modified lines stay in the buffer and reach memory only when they are later chosen for replacement.

The controller is a five-state machine. IDLE accepts requests and finishes hits and control operations in place. IDLE goes to FETCH on a miss and to PLACE_NEW on a hit to committed data. FETCH waits for the bus, then goes to PLACE_OLD on OK and back to IDLE on BUSY. PLACE_OLD installs the pre-transaction copy and goes to PLACE_NEW. PLACE_NEW installs the tentative copy and returns to IDLE. Either PLACE state goes to EVICT when its victim is modified; EVICT waits for the write-back and returns to the PLACE state it came from. Either PLACE state returns to IDLE on overflow.

Top module: `txn_cache`

## Requirements
- R1: After reset, tx_active is 0, tx_status is 1, req_ready is 1, and every entry is empty, so the first access to any line goes to the bus.
- R2: A transactional read that misses issues bus kind 0 (shared fetch). An exclusive read or a write that misses issues bus kind 1 (exclusive fetch). The request carries the line address and stays asserted, with a stable address and kind, until bus_rsp_valid.
- R3: An OK fetch installs an old/new pair and answers rsp_ok=1. For reads rsp_data is the fetched data; for a write it is the written data. Later accesses to that line within the transaction hit the tentative copy without bus traffic, and a write updates the value that later reads return.
- R4: A BUSY fetch discards all tentative copies, restores all old copies, answers rsp_ok=0 with rsp_data=0, and leaves tx_active=1 with tx_status=0.
- R5: The first transactional access while no transaction is active sets tx_active to 1.
- R6: While tx_active=1 and tx_status=0, a transactional access answers rsp_ok=0 and rsp_data=0 in the next cycle, with no bus request.
- R7: Op 4 (commit) with tx_status=1 answers rsp_ok=1, drops the old copies and makes the tentative copies committed. A later transaction then reads the new value without bus traffic.
- R8: Commit with tx_status=0 answers rsp_ok=0 and restores the old copies instead. After any commit, tx_active=0 and tx_status=1.
- R9: Op 5 (abort) answers rsp_ok=1, drops the tentative copies, makes the old copies committed, and sets tx_active=0 and tx_status=1.
- R10: Op 3 (validate) answers rsp_ok equal to tx_status. When tx_status=1 the flags are unchanged. When tx_status=0 the old copies are restored and the flags become tx_active=0 and tx_status=1.
- R11: An access that hits committed data turns that entry into the old copy and places a tentative copy in another entry, with no bus request.
- R12: A free entry is chosen first, then a committed entry, then an old copy, lowest index first within each class; an entry holding the requested line is never chosen. A modified victim is first written back with bus kind 2 carrying its address and data; a clean victim is overwritten silently.
- R13: When only tentative copies or entries for the requested line remain, the access fails as in R4: rsp_ok=0, tx_status=0, old copies restored.
- R14: Commit, abort and validate answer in the cycle after acceptance and never issue a bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Controller idle, request taken |
| req_op | input | 3 | 0 read, 1 exclusive read, 2 write, 3 validate, 4 commit, 5 abort |
| req_addr | input | ADDR_W | Line address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_ok | output | 1 | Success / check result |
| rsp_data | output | DATA_W | Line value (0 on failure) |
| tx_active | output | 1 | Transaction in progress |
| tx_status | output | 1 | Transaction not yet conflicted |
| bus_req_valid | output | 1 | Bus request held until answered |
| bus_req_kind | output | 2 | 0 shared fetch, 1 exclusive fetch, 2 write-back |
| bus_req_addr | output | ADDR_W | Bus line address |
| bus_req_data | output | DATA_W | Write-back data |
| bus_rsp_valid | input | 1 | Bus answer |
| bus_rsp_busy | input | 1 | Fetch refused |
| bus_rsp_data | input | DATA_W | Fetched data |

## Verification
The bench drives a line-level model through write sequences that fill the buffer until committed modified lines must be written back. It then continues until only tentative copies remain. A wrong victim order shows up as a write-back of the wrong line, or of a line the transaction still needs. The bench aborts after a write to check that the old value comes back, not the tentative one. It commits and validates an orphan to check that failure is reported and the flags are cleared, and it validates a live transaction to check that the flags survive. A refused fetch followed by further accesses checks that the orphan reaches neither the bus nor the data.

// File: rtl/txc_pkg.sv
package txc_pkg;
    typedef enum logic [1:0] {TG_EMPTY, TG_NORMAL, TG_XCOMMIT, TG_XABORT} txc_tag_e;
    typedef enum logic [1:0] {CS_INVALID, CS_VALID, CS_DIRTY, CS_RESERVED} txc_coh_e;
    typedef enum logic [2:0] {OP_LT = 3'd0, OP_LTX = 3'd1, OP_ST = 3'd2,
                              OP_VALIDATE = 3'd3, OP_COMMIT = 3'd4, OP_ABORT = 3'd5} txc_op_e;
    typedef enum logic [1:0] {BK_SHARED = 2'd0, BK_EXCL = 2'd1, BK_WRITE = 2'd2} txc_bus_e;
    typedef enum logic [2:0] {S_IDLE, S_FETCH, S_PLACE_OLD, S_PLACE_NEW, S_EVICT} txc_fsm_e;
endpackage

// File: rtl/txc_prio.sv
module txc_prio #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        found_o = |vec_i;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/txc_lookup.sv
module txc_lookup
    import txc_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  txc_tag_e          tag_i  [ENTRIES],
    input  logic [ADDR_W-1:0] addr_i [ENTRIES],
    input  logic [ADDR_W-1:0] key_i,
    output logic              xa_hit_o,
    output logic [IDX_W-1:0]  xa_idx_o,
    output logic              nm_hit_o,
    output logic [IDX_W-1:0]  nm_idx_o
);
    logic [ENTRIES-1:0] xa_match, nm_match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign xa_match[g] = (tag_i[g] == TG_XABORT) && (addr_i[g] == key_i);
        assign nm_match[g] = (tag_i[g] == TG_NORMAL) && (addr_i[g] == key_i);
    end

    txc_prio #(.N(ENTRIES), .IDX_W(IDX_W)) u_xa (.vec_i(xa_match), .found_o(xa_hit_o), .idx_o(xa_idx_o));
    txc_prio #(.N(ENTRIES), .IDX_W(IDX_W)) u_nm (.vec_i(nm_match), .found_o(nm_hit_o), .idx_o(nm_idx_o));

    // R3
    xa_unique_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(xa_match));
    // R11
    nm_unique_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(nm_match));
endmodule

// File: rtl/txc_victim.sv
module txc_victim
    import txc_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  txc_tag_e          tag_i  [ENTRIES],
    input  txc_coh_e          coh_i  [ENTRIES],
    input  logic [ADDR_W-1:0] addr_i [ENTRIES],
    input  logic [ADDR_W-1:0] key_i,
    output logic              found_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              wb_o
);
    logic [ENTRIES-1:0] free_v, norm_v, old_v;
    logic               f_hit, n_hit, o_hit;
    logic [IDX_W-1:0]   f_idx, n_idx, o_idx;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cls
        assign free_v[g] = (tag_i[g] == TG_EMPTY);
        assign norm_v[g] = (tag_i[g] == TG_NORMAL)  && (addr_i[g] != key_i);
        assign old_v[g]  = (tag_i[g] == TG_XCOMMIT) && (addr_i[g] != key_i);
    end

    txc_prio #(.N(ENTRIES), .IDX_W(IDX_W)) u_f (.vec_i(free_v), .found_o(f_hit), .idx_o(f_idx));
    txc_prio #(.N(ENTRIES), .IDX_W(IDX_W)) u_n (.vec_i(norm_v), .found_o(n_hit), .idx_o(n_idx));
    txc_prio #(.N(ENTRIES), .IDX_W(IDX_W)) u_o (.vec_i(old_v),  .found_o(o_hit), .idx_o(o_idx));

    always_comb begin
        found_o = f_hit | n_hit | o_hit;
        if (f_hit)      idx_o = f_idx;
        else if (n_hit) idx_o = n_idx;
        else            idx_o = o_idx;
        wb_o = found_o && (tag_i[idx_o] != TG_EMPTY) && (coh_i[idx_o] == CS_DIRTY);
    end
endmodule

// File: rtl/txc_flags.sv
module txc_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic fail_i,
    input  logic clear_i,
    output logic active_o,
    output logic status_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            status_o <= 1'b1;
        end else if (clear_i) begin
            active_o <= 1'b0;
            status_o <= 1'b1;
        end else begin
            if (start_i) active_o <= 1'b1;
            if (fail_i)  status_o <= 1'b0;
        end
    end

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (!active_o && status_o));
    // R4
    flag_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_i && !clear_i) |=> (!status_o && active_o));
endmodule

// File: rtl/txn_cache.sv
module txn_cache
    import txc_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic [DATA_W-1:0] rsp_data,
    output logic              tx_active,
    output logic              tx_status,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_kind,
    output logic [ADDR_W-1:0] bus_req_addr,
    output logic [DATA_W-1:0] bus_req_data,
    input  logic              bus_rsp_valid,
    input  logic              bus_rsp_busy,
    input  logic [DATA_W-1:0] bus_rsp_data
);
    localparam int IDX_W = $clog2(ENTRIES);

    txc_fsm_e          state, nxt, ret_state;
    txc_tag_e          e_tag  [ENTRIES];
    txc_coh_e          e_coh  [ENTRIES];
    logic [ADDR_W-1:0] e_addr [ENTRIES];
    logic [DATA_W-1:0] e_data [ENTRIES];

    logic [2:0]        cur_op;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata, old_data, new_data;
    txc_coh_e          old_coh, new_coh;
    logic [IDX_W-1:0]  wb_idx;

    logic              xa_hit, nm_hit, vic_found, vic_wb;
    logic [IDX_W-1:0]  xa_idx, nm_idx, vic_idx;
    logic [ADDR_W-1:0] look_key;
    logic fire, op_txn, orphan, bus_ok, bus_busy, in_place, overflow;
    logic sweep_commit, sweep_abort, flag_start, flag_fail, flag_clear;

    assign look_key = (state == S_IDLE) ? req_addr : cur_addr;

    txc_lookup #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_lookup (
        .clk(clk), .rst_n(rst_n), .tag_i(e_tag), .addr_i(e_addr), .key_i(look_key),
        .xa_hit_o(xa_hit), .xa_idx_o(xa_idx), .nm_hit_o(nm_hit), .nm_idx_o(nm_idx));

    txc_victim #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_victim (
        .tag_i(e_tag), .coh_i(e_coh), .addr_i(e_addr), .key_i(cur_addr),
        .found_o(vic_found), .idx_o(vic_idx), .wb_o(vic_wb));

    txc_flags u_flags (
        .clk(clk), .rst_n(rst_n), .start_i(flag_start), .fail_i(flag_fail),
        .clear_i(flag_clear), .active_o(tx_active), .status_o(tx_status));

    // decode of the current cycle's events
    always_comb begin
        fire     = (state == S_IDLE) && req_valid;
        op_txn   = (req_op == OP_LT) || (req_op == OP_LTX) || (req_op == OP_ST);
        orphan   = tx_active && !tx_status;
        bus_ok   = (state == S_FETCH) && bus_rsp_valid && !bus_rsp_busy;
        bus_busy = (state == S_FETCH) && bus_rsp_valid && bus_rsp_busy;
        in_place = (state == S_PLACE_OLD) || (state == S_PLACE_NEW);
        overflow = in_place && !vic_found;
        sweep_commit = fire && (req_op == OP_COMMIT) && tx_status;
        sweep_abort  = (fire && ((req_op == OP_ABORT) ||
                        (((req_op == OP_VALIDATE) || (req_op == OP_COMMIT)) && !tx_status)))
                       || bus_busy || overflow;
        flag_start = fire && op_txn && !tx_active;
        flag_fail  = bus_busy || overflow;
        flag_clear = fire && ((req_op == OP_ABORT) || (req_op == OP_COMMIT) ||
                              ((req_op == OP_VALIDATE) && !tx_status));
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (fire && op_txn && !orphan && !xa_hit)
                    nxt = nm_hit ? S_PLACE_NEW : S_FETCH;
            end
            S_FETCH: begin
                if (bus_busy)    nxt = S_IDLE;
                else if (bus_ok) nxt = S_PLACE_OLD;
            end
            S_PLACE_OLD: begin
                if (!vic_found)  nxt = S_IDLE;
                else if (vic_wb) nxt = S_EVICT;
                else             nxt = S_PLACE_NEW;
            end
            S_PLACE_NEW: begin
                if (!vic_found)  nxt = S_IDLE;
                else if (vic_wb) nxt = S_EVICT;
                else             nxt = S_IDLE;
            end
            S_EVICT: begin
                if (bus_rsp_valid) nxt = ret_state;
            end
            default: nxt = S_IDLE;
        endcase
    end

    // outputs toward core and bus
    always_comb begin
        req_ready     = (state == S_IDLE);
        bus_req_valid = (state == S_FETCH) || (state == S_EVICT);
    end

    // entry array and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                e_tag[i]  <= TG_EMPTY;
                e_coh[i]  <= CS_INVALID;
                e_addr[i] <= '0;
                e_data[i] <= '0;
            end
            cur_op       <= '0;
            cur_addr     <= '0;
            cur_wdata    <= '0;
            old_data     <= '0;
            new_data     <= '0;
            old_coh      <= CS_INVALID;
            new_coh      <= CS_INVALID;
            wb_idx       <= '0;
            ret_state    <= S_PLACE_OLD;
            bus_req_kind <= '0;
            bus_req_addr <= '0;
            bus_req_data <= '0;
            rsp_valid    <= 1'b0;
            rsp_ok       <= 1'b0;
            rsp_data     <= '0;
        end else begin
            rsp_valid <= 1'b0;
            for (int i = 0; i < ENTRIES; i++) begin
                if (sweep_commit) begin
                    if (e_tag[i] == TG_XCOMMIT) begin
                        e_tag[i] <= TG_EMPTY;
                        e_coh[i] <= CS_INVALID;
                    end else if (e_tag[i] == TG_XABORT) begin
                        e_tag[i] <= TG_NORMAL;
                    end
                end
                if (sweep_abort) begin
                    if (e_tag[i] == TG_XABORT) begin
                        e_tag[i] <= TG_EMPTY;
                        e_coh[i] <= CS_INVALID;
                    end else if (e_tag[i] == TG_XCOMMIT) begin
                        e_tag[i] <= TG_NORMAL;
                    end
                end
            end
            unique case (state)
                S_IDLE: begin
                    if (fire) begin
                        cur_op    <= req_op;
                        cur_addr  <= req_addr;
                        cur_wdata <= req_wdata;
                        if (op_txn) begin
                            if (orphan) begin
                                rsp_valid <= 1'b1;
                                rsp_ok    <= 1'b0;
                                rsp_data  <= '0;
                            end else if (xa_hit) begin
                                rsp_valid <= 1'b1;
                                rsp_ok    <= 1'b1;
                                if (req_op == OP_ST) begin
                                    e_data[xa_idx] <= req_wdata;
                                    e_coh[xa_idx]  <= CS_DIRTY;
                                    rsp_data       <= req_wdata;
                                end else begin
                                    rsp_data <= e_data[xa_idx];
                                end
                            end else if (nm_hit) begin
                                e_tag[nm_idx] <= TG_XCOMMIT;
                                new_data <= (req_op == OP_ST) ? req_wdata : e_data[nm_idx];
                                new_coh  <= (req_op == OP_ST) ? CS_DIRTY  : e_coh[nm_idx];
                            end else begin
                                bus_req_kind <= (req_op == OP_LT) ? BK_SHARED : BK_EXCL;
                                bus_req_addr <= req_addr;
                                bus_req_data <= '0;
                            end
                        end else begin
                            rsp_valid <= 1'b1;
                            rsp_data  <= '0;
                            if ((req_op == OP_VALIDATE) || (req_op == OP_COMMIT))
                                rsp_ok <= tx_status;
                            else
                                rsp_ok <= (req_op == OP_ABORT);
                        end
                    end
                end
                S_FETCH: begin
                    if (bus_busy) begin
                        rsp_valid <= 1'b1;
                        rsp_ok    <= 1'b0;
                        rsp_data  <= '0;
                    end else if (bus_ok) begin
                        old_data <= bus_rsp_data;
                        old_coh  <= (cur_op == OP_LT) ? CS_VALID : CS_RESERVED;
                        new_data <= (cur_op == OP_ST) ? cur_wdata : bus_rsp_data;
                        new_coh  <= (cur_op == OP_ST) ? CS_DIRTY :
                                    ((cur_op == OP_LT) ? CS_VALID : CS_RESERVED);
                    end
                end
                S_PLACE_OLD, S_PLACE_NEW: begin
                    if (!vic_found) begin
                        rsp_valid <= 1'b1;
                        rsp_ok    <= 1'b0;
                        rsp_data  <= '0;
                    end else if (vic_wb) begin
                        bus_req_kind <= BK_WRITE;
                        bus_req_addr <= e_addr[vic_idx];
                        bus_req_data <= e_data[vic_idx];
                        wb_idx       <= vic_idx;
                        ret_state    <= state;
                    end else begin
                        e_addr[vic_idx] <= cur_addr;
                        if (state == S_PLACE_OLD) begin
                            e_tag[vic_idx]  <= TG_XCOMMIT;
                            e_data[vic_idx] <= old_data;
                            e_coh[vic_idx]  <= old_coh;
                        end else begin
                            e_tag[vic_idx]  <= TG_XABORT;
                            e_data[vic_idx] <= new_data;
                            e_coh[vic_idx]  <= new_coh;
                            rsp_valid <= 1'b1;
                            rsp_ok    <= 1'b1;
                            rsp_data  <= new_data;
                        end
                    end
                end
                S_EVICT: begin
                    if (bus_rsp_valid) begin
                        e_tag[wb_idx] <= TG_EMPTY;
                        e_coh[wb_idx] <= CS_INVALID;
                    end
                end
                default: ;
            endcase
        end
    end

    // R2
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && !bus_rsp_valid) |=>
            (bus_req_valid && $stable(bus_req_addr) && $stable(bus_req_kind)));
    // R6
    orphan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_op <= 3'd2) && tx_active && !tx_status) |=>
            (rsp_valid && !rsp_ok && !bus_req_valid));
    // R8
    commit_orphan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_op == 3'd4) && !tx_status) |=> (rsp_valid && !rsp_ok));
    // R14
    ctrl_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_op >= 3'd3) && (req_op <= 3'd5)) |=>
            (rsp_valid && !bus_req_valid && req_ready));
    // R12
    install_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_place && vic_found && !vic_wb) |-> (e_tag[vic_idx] != TG_XABORT));
endmodule

// File: tb/txn_cache_tb.sv
module txn_cache_tb;
    localparam int N  = 8;
    localparam int AW = 16;
    localparam int DW = 64;
    localparam int T_EMPTY = 0, T_NORM = 1, T_XC = 2, T_XA = 3;
    localparam int O_LT = 0, O_LTX = 1, O_ST = 2, O_VAL = 3, O_COM = 4, O_ABT = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [2:0] req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic rsp_valid, rsp_ok, tx_active, tx_status, bus_req_valid;
    logic [DW-1:0] rsp_data, bus_req_data;
    logic [1:0] bus_req_kind;
    logic [AW-1:0] bus_req_addr;
    logic bus_rsp_valid = 1'b0, bus_rsp_busy = 1'b0;
    logic [DW-1:0] bus_rsp_data = '0;

    always #4 clk = ~clk;

    txn_cache #(.ENTRIES(N), .ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_data(rsp_data),
        .tx_active(tx_active), .tx_status(tx_status),
        .bus_req_valid(bus_req_valid), .bus_req_kind(bus_req_kind),
        .bus_req_addr(bus_req_addr), .bus_req_data(bus_req_data),
        .bus_rsp_valid(bus_rsp_valid), .bus_rsp_busy(bus_rsp_busy), .bus_rsp_data(bus_rsp_data));

    int checks = 0, fails = 0;

    // behavioural reference: line slots, flags, backing memory
    int            m_tag   [N];
    logic [AW-1:0] m_addr  [N];
    logic [DW-1:0] m_data  [N];
    bit            m_dirty [N];
    bit            m_act = 0, m_st = 1, m_ovf = 0;
    logic [DW-1:0] mem [int];
    int            exp_k [$];
    logic [AW-1:0] exp_a [$];
    logic [DW-1:0] exp_d [$];
    int            wb_seen = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] mem_rd(input logic [AW-1:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return 64'hC0DE_0000_0000_0000 | DW'(a);
    endfunction

    function automatic int m_find(input int tg, input logic [AW-1:0] a);
        for (int i = 0; i < N; i++) if (m_tag[i] == tg && m_addr[i] == a) return i;
        return -1;
    endfunction

    function automatic int m_victim(input logic [AW-1:0] a);
        for (int i = 0; i < N; i++) if (m_tag[i] == T_EMPTY) return i;
        for (int i = 0; i < N; i++) if (m_tag[i] == T_NORM && m_addr[i] != a) return i;
        for (int i = 0; i < N; i++) if (m_tag[i] == T_XC && m_addr[i] != a) return i;
        return -1;
    endfunction

    function automatic void m_abort();
        for (int i = 0; i < N; i++) begin
            if (m_tag[i] == T_XA) m_tag[i] = T_EMPTY;
            else if (m_tag[i] == T_XC) m_tag[i] = T_NORM;
        end
    endfunction

    function automatic void m_commit();
        for (int i = 0; i < N; i++) begin
            if (m_tag[i] == T_XC) m_tag[i] = T_EMPTY;
            else if (m_tag[i] == T_XA) m_tag[i] = T_NORM;
        end
    endfunction

    function automatic bit m_alloc(input int tg, input logic [AW-1:0] a,
                                   input logic [DW-1:0] d, input bit dirty);
        int v;
        v = m_victim(a);
        if (v < 0) begin
            m_ovf = 1;
            return 0;
        end
        if (m_tag[v] != T_EMPTY && m_dirty[v]) begin
            exp_k.push_back(2); exp_a.push_back(m_addr[v]); exp_d.push_back(m_data[v]);
            mem[int'(m_addr[v])] = m_data[v];
        end
        m_tag[v] = tg; m_addr[v] = a; m_data[v] = d; m_dirty[v] = dirty;
        return 1;
    endfunction

    task automatic model(input int op, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                         input bit busy, output bit eok, output logic [DW-1:0] ed);
        int x;
        logic [DW-1:0] nd, od;
        bit nd_dirty;
        eok = 0; ed = '0;
        exp_k.delete(); exp_a.delete(); exp_d.delete();
        if (op <= O_ST) begin
            if (m_act && !m_st) return;
            m_act = 1;
            x = m_find(T_XA, a);
            if (x >= 0) begin
                if (op == O_ST) begin m_data[x] = wd; m_dirty[x] = 1; end
                eok = 1; ed = m_data[x];
                return;
            end
            x = m_find(T_NORM, a);
            if (x >= 0) begin
                m_tag[x] = T_XC;
                nd = (op == O_ST) ? wd : m_data[x];
                nd_dirty = (op == O_ST) ? 1'b1 : m_dirty[x];
            end else begin
                exp_k.push_back(op == O_LT ? 0 : 1); exp_a.push_back(a); exp_d.push_back('0);
                if (busy) begin m_abort(); m_st = 0; return; end
                od = mem_rd(a);
                nd = (op == O_ST) ? wd : od;
                nd_dirty = (op == O_ST);
                if (!m_alloc(T_XC, a, od, 1'b0)) begin m_abort(); m_st = 0; return; end
            end
            if (!m_alloc(T_XA, a, nd, nd_dirty)) begin m_abort(); m_st = 0; return; end
            eok = 1; ed = nd;
        end else if (op == O_VAL) begin
            eok = m_st;
            if (!m_st) begin m_abort(); m_act = 0; m_st = 1; end
        end else if (op == O_COM) begin
            eok = m_st;
            if (m_st) m_commit(); else m_abort();
            m_act = 0; m_st = 1;
        end else begin
            m_abort(); m_act = 0; m_st = 1; eok = 1;
        end
    endtask

    // one core operation: predict, drive, act as bus, compare
    task automatic run(input int op, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                       input bit busy, input string req);
        bit eok, got, just;
        logic [DW-1:0] ed, g_data;
        bit g_ok;
        int nb, cnt;
        model(op, a, wd, busy, eok, ed);
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'(op); req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        got = 0; nb = 0; cnt = 0; g_ok = 0; g_data = '0;
        while (!got && cnt < 200) begin
            just = 0;
            if (bus_rsp_valid) begin bus_rsp_valid = 1'b0; just = 1; end
            if (rsp_valid) begin
                got = 1; g_ok = rsp_ok; g_data = rsp_data;
                check(tx_active == m_act, req, "tx_active", DW'(tx_active), DW'(m_act));
                check(tx_status == m_st, req, "tx_status", DW'(tx_status), DW'(m_st));
            end else if (!just && bus_req_valid) begin
                if (nb < exp_k.size()) begin
                    check(int'(bus_req_kind) == exp_k[nb], req, "bus kind", DW'(bus_req_kind), DW'(exp_k[nb]));
                    check(bus_req_addr == exp_a[nb], req, "bus addr", DW'(bus_req_addr), DW'(exp_a[nb]));
                    if (exp_k[nb] == 2)
                        check(bus_req_data == exp_d[nb], req, "write-back data", bus_req_data, exp_d[nb]);
                end
                if (bus_req_kind == 2'd2) wb_seen++;
                nb++;
                bus_rsp_valid = 1'b1;
                bus_rsp_busy  = busy && (bus_req_kind != 2'd2);
                bus_rsp_data  = (bus_req_kind == 2'd2) ? '0 : mem_rd(bus_req_addr);
            end
            if (!got) begin @(negedge clk); cnt++; end
        end
        bus_rsp_valid = 1'b0;
        check(got, req, "response seen", DW'(got), 64'd1);
        check(nb == exp_k.size(), req, "bus request count", DW'(nb), DW'(exp_k.size()));
        check(g_ok == eok, req, "rsp_ok", DW'(g_ok), DW'(eok));
        check(g_data == ed, req, "rsp_data", g_data, ed);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bit ovf_seen;
        for (int i = 0; i < N; i++) begin
            m_tag[i] = T_EMPTY; m_addr[i] = '0; m_data[i] = '0; m_dirty[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(tx_active == 1'b0, "R1", "tx_active", DW'(tx_active), 64'd0);
        check(tx_status == 1'b1, "R1", "tx_status", DW'(tx_status), 64'd1);
        check(req_ready == 1'b1, "R1", "req_ready", DW'(req_ready), 64'd1);
        check(!bus_req_valid && !rsp_valid, "R1", "idle outputs", DW'(bus_req_valid), 64'd0);

        run(O_LT,  16'h0010, '0, 0, "R1 R2 R5 first read misses");
        run(O_LT,  16'h0010, '0, 0, "R3 reread hits");
        run(O_ST,  16'h0010, 64'h77, 0, "R3 write to tentative copy");
        run(O_LT,  16'h0010, '0, 0, "R3 read sees write");
        run(O_LTX, 16'h0020, '0, 0, "R2 exclusive read miss");
        run(O_ST,  16'h0030, 64'h33, 0, "R2 write miss");
        run(O_VAL, '0, '0, 0, "R10 validate live");
        run(O_COM, '0, '0, 0, "R7 R14 commit");
        run(O_LT,  16'h0010, '0, 0, "R7 R11 committed hit");
        run(O_ST,  16'h0020, 64'h99, 0, "R11 write to committed line");
        run(O_ABT, '0, '0, 0, "R9 abort");
        run(O_LT,  16'h0020, '0, 0, "R9 old value restored");
        run(O_COM, '0, '0, 0, "R7 commit");
        run(O_LT,  16'h0040, '0, 1, "R4 busy fetch");
        run(O_LT,  16'h0010, '0, 0, "R6 orphan access");
        run(O_VAL, '0, '0, 0, "R10 validate orphan");
        run(O_LTX, 16'h0050, '0, 1, "R4 busy exclusive");
        run(O_COM, '0, '0, 0, "R8 commit orphan");
        run(O_LT,  16'h0010, '0, 0, "R8 old copy kept");
        run(O_COM, '0, '0, 0, "R7 commit");
        for (int i = 0; i < 3; i++)
            run(O_ST, AW'(16'h0100 + i), 64'hE000 + i, 0, "R12 dirty fill");
        run(O_COM, '0, '0, 0, "R7 commit dirty lines");
        ovf_seen = 0;
        for (int i = 0; i < 10; i++) begin
            run(O_ST, AW'(16'h0200 + i), 64'hF000 + i, 0, "R12 R13 replacement");
            if (m_ovf) ovf_seen = 1;
        end
        check(wb_seen > 0, "R12", "write-backs seen", DW'(wb_seen), 64'd1);
        check(ovf_seen, "R13", "overflow reached", DW'(ovf_seen), 64'd1);
        run(O_VAL, '0, '0, 0, "R13 R10 validate after overflow");
        run(O_LT,  16'h0100, '0, 0, "R12 written-back line refetch");
        run(O_ABT, '0, '0, 0, "R9 abort");
        repeat (2) @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule